// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home memory node of a small distributed shared-memory machine and keeps each of its memory blocks coherent across the caching nodes. It does not snoop. For every block it holds a directory entry with three parts: a state (no cached copies, clean copies, or one modified copy), one presence bit per node, and a modified bit. It also holds the block's data word. Read-miss and write-miss requests come in from the nodes on one valid/ready message channel, together with invalidation acknowledgements and owner data returns. The controller answers on a second valid/ready channel with data replies, owner-forwarding notices, fetch requests to owners, invalidations, write grants and retry refusals.

A write does not complete until every other holder of the block has confirmed that its copy is invalidated. A read of a modified block points the requester at the owner and asks the owner for the data. The directory is updated when the owner returns that data. Each block can have one transaction in flight, and any other block can have its own at the same time. A miss to a block whose transaction is still open gets a retry refusal. A lookup port shows the directory entry of any block so that the entry can be inspected.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is uncached (state code 0) with no presence bits and a clear modified bit. `in_ready` is 1 and `out_valid` is 0. Each block's data word is 0xC0DE0000 plus its block index.
- R2: A read miss (in_kind 0) to a block in state 0 or 1 that has no open transaction is answered with one DATA message (out_kind 0) to the requester, carrying the stored word. The requester's presence bit is then set, the state becomes shared (code 1) and the modified bit stays clear.
- R3: A read miss to a dirty block (state code 2) that has no open transaction sends two messages, in this order. First an OWNER message (out_kind 1) goes to the requester with `out_node` set to the owner. Then a FETCH message (out_kind 5) goes to the owner with `out_node` set to the requester. The block's transaction stays open.
- R4: Owner data (in_kind 3) from the awaited owner of an open read writes the data word into memory, clears the modified bit, sets the state to shared, and sets exactly the owner's and the requester's presence bits. No message is sent.
- R5: A write miss (in_kind 1) to a block with no open transaction, where nodes other than the requester are present, sends one INVAL (out_kind 2) to each of those nodes in ascending node order. The requester is never sent an INVAL. `out_node` carries the requester.
- R6: A write is granted only when an acknowledgement (in_kind 2) has arrived from every invalidated node. On the last one, a GRANT (out_kind 3) goes to the writer. After the grant the state is dirty, the modified bit is set, and only the writer's presence bit is set.
- R7: A write miss to a block with no open transaction and no other present node is granted at once with a GRANT that carries the stored word.
- R8: A read or write miss to a block whose transaction is open gets a NACK (out_kind 4) to the requester. The directory entry is not changed.
- R9: An acknowledgement or owner data that the block's open transaction is not waiting for has no effect: no message is sent and the entry is not changed.
- R10: While `out_valid` is high and `out_ready` is low, the output message holds steady. No input is accepted while a message is pending.
- R11: When the invalidated node was the dirty owner, its acknowledgement's data word is written to memory, and the grant carries that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound message valid |
| in_ready | output | 1 | Controller can take an inbound message |
| in_kind | input | 2 | 0 read miss, 1 write miss, 2 invalidation ack, 3 owner data |
| in_src | input | log2(NODES) | Sending node |
| in_blk | input | log2(BLOCKS) | Block index |
| in_data | input | DW | Data word (ack from a dirty owner, owner data) |
| out_valid | output | 1 | Outbound message valid |
| out_ready | input | 1 | Network can take the outbound message |
| out_kind | output | 3 | 0 DATA, 1 OWNER, 2 INVAL, 3 GRANT, 4 NACK, 5 FETCH |
| out_dst | output | log2(NODES) | Destination node |
| out_blk | output | log2(BLOCKS) | Block index |
| out_node | output | log2(NODES) | Owner for OWNER; requester for INVAL/FETCH; destination otherwise |
| out_data | output | DW | Data word for DATA and GRANT, zero otherwise |
| look_blk | input | log2(BLOCKS) | Block whose directory entry is shown |
| look_state | output | 2 | 0 uncached, 1 shared, 2 dirty |
| look_presence | output | NODES | Presence bits of the shown block |
| look_modified | output | 1 | Modified bit of the shown block |

## Verification
The hardest cases to reach are those where a transaction is still open. These include the window between the invalidations and the last acknowledgement, and the wait for owner data after a dirty read. New misses to the same block, stray or duplicate acknowledgements, and an acknowledgement from a former dirty owner that carries data all have to arrive inside that window. Directed steps hold a block open and aim those messages at it one at a time. A random phase then keeps the expected acknowledgements and owner returns in a pool and releases them in random order. Its misses are mixed in and limited to four blocks, so collisions are frequent. A reference model predicts each outbound message and each directory entry.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        BLK_UNCACHED = 2'd0,
        BLK_SHARED   = 2'd1,
        BLK_DIRTY    = 2'd2
    } blk_state_e;

    typedef enum logic [1:0] {
        IN_RD_MISS    = 2'd0,
        IN_WR_MISS    = 2'd1,
        IN_INV_ACK    = 2'd2,
        IN_OWNER_DATA = 2'd3
    } in_kind_e;

    typedef enum logic [2:0] {
        OUT_DATA  = 3'd0,
        OUT_OWNER = 3'd1,
        OUT_INVAL = 3'd2,
        OUT_GRANT = 3'd3,
        OUT_NACK  = 3'd4,
        OUT_FETCH = 3'd5
    } out_kind_e;

    // index of the lowest set bit, 0 when none is set
    function automatic int unsigned low_index(input logic [63:0] v);
        int unsigned idx;
        idx = 0;
        for (int i = 63; i >= 0; i--) begin
            if (v[i]) idx = i;
        end
        return idx;
    endfunction

    // power-on content of a memory word
    function automatic logic [31:0] init_word(input int unsigned blk);
        return 32'hC0DE_0000 + blk;
    endfunction

endpackage

// File: rtl/dir_table.sv
module dir_table
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 16,
    parameter int DW     = 32,
    parameter int BW     = $clog2(BLOCKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BW-1:0]    rd_blk,
    output blk_state_e       rd_state,
    output logic [NODES-1:0] rd_pres,
    output logic             rd_mod,
    output logic [DW-1:0]    rd_data,
    input  logic [BW-1:0]    lk_blk,
    output blk_state_e       lk_state,
    output logic [NODES-1:0] lk_pres,
    output logic             lk_mod,
    input  logic             wr_en,
    input  logic [BW-1:0]    wr_blk,
    input  blk_state_e       wr_state,
    input  logic [NODES-1:0] wr_pres,
    input  logic             wr_mod,
    input  logic             mem_we,
    input  logic [DW-1:0]    mem_data
);

    blk_state_e       st_q   [BLOCKS];
    logic [NODES-1:0] pres_q [BLOCKS];
    logic             mod_q  [BLOCKS];
    logic [DW-1:0]    mem_q  [BLOCKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < BLOCKS; b++) begin
                st_q[b]   <= BLK_UNCACHED;
                pres_q[b] <= '0;
                mod_q[b]  <= 1'b0;
                mem_q[b]  <= DW'(init_word(b));
            end
        end else begin
            if (wr_en) begin
                st_q[wr_blk]   <= wr_state;
                pres_q[wr_blk] <= wr_pres;
                mod_q[wr_blk]  <= wr_mod;
            end
            if (mem_we) begin
                mem_q[wr_blk] <= mem_data;
            end
        end
    end

    assign rd_state = st_q[rd_blk];
    assign rd_pres  = pres_q[rd_blk];
    assign rd_mod   = mod_q[rd_blk];
    assign rd_data  = mem_q[rd_blk];
    assign lk_state = st_q[lk_blk];
    assign lk_pres  = pres_q[lk_blk];
    assign lk_mod   = mod_q[lk_blk];

endmodule

// File: rtl/dir_txn.sv
module dir_txn
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 16,
    parameter int NW     = $clog2(NODES),
    parameter int BW     = $clog2(BLOCKS),
    parameter int CW     = $clog2(NODES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BW-1:0]     t_blk,
    output logic              q_busy,
    output logic              q_write,
    output logic [NW-1:0]     q_req,
    output logic [NW-1:0]     q_owner,
    output logic              q_odirty,
    output logic [NODES-1:0]  q_wait,
    output logic [CW-1:0]     q_left,
    output logic [BLOCKS-1:0] busy_vec,
    input  logic              op_en,
    input  logic              op_write,
    input  logic [NW-1:0]     op_req,
    input  logic [NW-1:0]     op_owner,
    input  logic              op_odirty,
    input  logic [NODES-1:0]  op_wait,
    input  logic              ak_en,
    input  logic [NW-1:0]     ak_node,
    input  logic              cl_en
);

    logic [BLOCKS-1:0] busy_q;
    logic              wr_q     [BLOCKS];
    logic [NW-1:0]     req_q    [BLOCKS];
    logic [NW-1:0]     own_q    [BLOCKS];
    logic              odirty_q [BLOCKS];
    logic [NODES-1:0]  wait_q   [BLOCKS];
    logic [CW-1:0]     left_q   [BLOCKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            for (int b = 0; b < BLOCKS; b++) begin
                wr_q[b]     <= 1'b0;
                req_q[b]    <= '0;
                own_q[b]    <= '0;
                odirty_q[b] <= 1'b0;
                wait_q[b]   <= '0;
                left_q[b]   <= '0;
            end
        end else begin
            if (op_en) begin
                busy_q[t_blk]   <= 1'b1;
                wr_q[t_blk]     <= op_write;
                req_q[t_blk]    <= op_req;
                own_q[t_blk]    <= op_owner;
                odirty_q[t_blk] <= op_odirty;
                wait_q[t_blk]   <= op_wait;
                left_q[t_blk]   <= CW'($countones(op_wait));
            end
            if (ak_en) begin
                wait_q[t_blk][ak_node] <= 1'b0;
                left_q[t_blk]          <= left_q[t_blk] - CW'(1);
            end
            if (cl_en) begin
                busy_q[t_blk] <= 1'b0;
            end
        end
    end

    assign q_busy   = busy_q[t_blk];
    assign q_write  = wr_q[t_blk];
    assign q_req    = req_q[t_blk];
    assign q_owner  = own_q[t_blk];
    assign q_odirty = odirty_q[t_blk];
    assign q_wait   = wait_q[t_blk];
    assign q_left   = left_q[t_blk];
    assign busy_vec = busy_q;

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int  NODES  = 4,
    parameter int  BLOCKS = 16,
    parameter int  DW     = 32,
    localparam int NW     = $clog2(NODES),
    localparam int BW     = $clog2(BLOCKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_kind,
    input  logic [NW-1:0]    in_src,
    input  logic [BW-1:0]    in_blk,
    input  logic [DW-1:0]    in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [2:0]       out_kind,
    output logic [NW-1:0]    out_dst,
    output logic [BW-1:0]    out_blk,
    output logic [NW-1:0]    out_node,
    output logic [DW-1:0]    out_data,
    input  logic [BW-1:0]    look_blk,
    output logic [1:0]       look_state,
    output logic [NODES-1:0] look_presence,
    output logic             look_modified
);

    localparam int CW = $clog2(NODES + 1);

    // directory table
    blk_state_e       rd_state, lk_state, tw_state;
    logic [NODES-1:0] rd_pres, tw_pres;
    logic             rd_mod, tw_mod, tw_en, mw_en;
    logic [DW-1:0]    rd_data, mw_data;

    // transaction table
    logic              q_busy, q_write, q_odirty;
    logic [NW-1:0]     q_req, q_owner;
    logic [NODES-1:0]  q_wait;
    logic [CW-1:0]     q_left;
    logic [BLOCKS-1:0] busy_vec;
    logic              op_en, op_write, op_odirty, ak_en, cl_en;
    logic [NW-1:0]     op_req, op_owner;
    logic [NODES-1:0]  op_wait;

    // outbound message register
    typedef struct packed {
        out_kind_e     kind;
        logic [NW-1:0] dst;
        logic [BW-1:0] blk;
        logic [NW-1:0] node;
        logic [DW-1:0] data;
    } msg_t;

    msg_t             o_msg, nx_msg;
    logic             o_valid, nx_emit;
    logic [NODES-1:0] rem_inv, nx_inv;
    logic             rem_fetch, nx_fetch;
    logic [NW-1:0]    f_dst, f_node, nx_fdst, nx_fnode;

    logic             acc;
    in_kind_e         kin;
    logic [NODES-1:0] src_bit, others;
    logic [NW-1:0]    pres_low;
    logic             owner_ack;

    dir_table #(.NODES(NODES), .BLOCKS(BLOCKS), .DW(DW), .BW(BW)) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_blk   (in_blk),
        .rd_state (rd_state),
        .rd_pres  (rd_pres),
        .rd_mod   (rd_mod),
        .rd_data  (rd_data),
        .lk_blk   (look_blk),
        .lk_state (lk_state),
        .lk_pres  (look_presence),
        .lk_mod   (look_modified),
        .wr_en    (tw_en),
        .wr_blk   (in_blk),
        .wr_state (tw_state),
        .wr_pres  (tw_pres),
        .wr_mod   (tw_mod),
        .mem_we   (mw_en),
        .mem_data (mw_data)
    );

    dir_txn #(.NODES(NODES), .BLOCKS(BLOCKS), .NW(NW), .BW(BW), .CW(CW)) u_txn (
        .clk       (clk),
        .rst       (rst),
        .t_blk     (in_blk),
        .q_busy    (q_busy),
        .q_write   (q_write),
        .q_req     (q_req),
        .q_owner   (q_owner),
        .q_odirty  (q_odirty),
        .q_wait    (q_wait),
        .q_left    (q_left),
        .busy_vec  (busy_vec),
        .op_en     (op_en),
        .op_write  (op_write),
        .op_req    (op_req),
        .op_owner  (op_owner),
        .op_odirty (op_odirty),
        .op_wait   (op_wait),
        .ak_en     (ak_en),
        .ak_node   (in_src),
        .cl_en     (cl_en)
    );

    assign in_ready   = !o_valid;
    assign acc        = in_valid && in_ready;
    assign kin        = in_kind_e'(in_kind);
    assign src_bit    = NODES'(1) << in_src;
    assign others     = rd_pres & ~src_bit;
    assign pres_low   = NW'(low_index(64'(rd_pres)));
    assign owner_ack  = q_odirty && (in_src == q_owner);
    assign look_state = lk_state;

    // decision for the accepted inbound message
    always_comb begin
        nx_emit   = 1'b0;
        nx_msg    = '{kind: OUT_DATA, dst: in_src, blk: in_blk, node: in_src, data: '0};
        nx_inv    = '0;
        nx_fetch  = 1'b0;
        nx_fdst   = '0;
        nx_fnode  = '0;
        tw_en     = 1'b0;
        tw_state  = BLK_UNCACHED;
        tw_pres   = '0;
        tw_mod    = 1'b0;
        mw_en     = 1'b0;
        mw_data   = in_data;
        op_en     = 1'b0;
        op_write  = 1'b0;
        op_req    = in_src;
        op_owner  = pres_low;
        op_odirty = 1'b0;
        op_wait   = '0;
        ak_en     = 1'b0;
        cl_en     = 1'b0;
        if (acc) begin
            unique case (kin)
                IN_RD_MISS: begin
                    nx_emit = 1'b1;
                    if (q_busy) begin
                        nx_msg.kind = OUT_NACK;
                    end else if (rd_state == BLK_DIRTY) begin
                        nx_msg.kind = OUT_OWNER;
                        nx_msg.node = pres_low;
                        nx_fetch    = 1'b1;
                        nx_fdst     = pres_low;
                        nx_fnode    = in_src;
                        op_en       = 1'b1;
                    end else begin
                        nx_msg.data = rd_data;
                        tw_en       = 1'b1;
                        tw_state    = BLK_SHARED;
                        tw_pres     = rd_pres | src_bit;
                    end
                end
                IN_WR_MISS: begin
                    nx_emit = 1'b1;
                    if (q_busy) begin
                        nx_msg.kind = OUT_NACK;
                    end else if (others == '0) begin
                        nx_msg.kind = OUT_GRANT;
                        nx_msg.data = rd_data;
                        tw_en       = 1'b1;
                        tw_state    = BLK_DIRTY;
                        tw_pres     = src_bit;
                        tw_mod      = 1'b1;
                    end else begin
                        nx_msg.kind = OUT_INVAL;
                        nx_msg.dst  = NW'(low_index(64'(others)));
                        nx_inv      = others & (others - NODES'(1));
                        op_en       = 1'b1;
                        op_write    = 1'b1;
                        op_odirty   = (rd_state == BLK_DIRTY);
                        op_wait     = others;
                    end
                end
                IN_INV_ACK: begin
                    if (q_busy && q_write && q_wait[in_src]) begin
                        ak_en = 1'b1;
                        mw_en = owner_ack;
                        if (q_left == CW'(1)) begin
                            cl_en       = 1'b1;
                            tw_en       = 1'b1;
                            tw_state    = BLK_DIRTY;
                            tw_pres     = NODES'(1) << q_req;
                            tw_mod      = 1'b1;
                            nx_emit     = 1'b1;
                            nx_msg.kind = OUT_GRANT;
                            nx_msg.dst  = q_req;
                            nx_msg.node = q_req;
                            nx_msg.data = owner_ack ? in_data : rd_data;
                        end
                    end
                end
                IN_OWNER_DATA: begin
                    if (q_busy && !q_write && (in_src == q_owner)) begin
                        mw_en    = 1'b1;
                        cl_en    = 1'b1;
                        tw_en    = 1'b1;
                        tw_state = BLK_SHARED;
                        tw_pres  = (NODES'(1) << q_owner) | (NODES'(1) << q_req);
                    end
                end
                default: ;
            endcase
        end
    end

    // outbound sequencer: first message, remaining invalidations, then fetch
    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid   <= 1'b0;
            o_msg     <= '0;
            rem_inv   <= '0;
            rem_fetch <= 1'b0;
            f_dst     <= '0;
            f_node    <= '0;
        end else if (acc && nx_emit) begin
            o_valid   <= 1'b1;
            o_msg     <= nx_msg;
            rem_inv   <= nx_inv;
            rem_fetch <= nx_fetch;
            f_dst     <= nx_fdst;
            f_node    <= nx_fnode;
        end else if (o_valid && out_ready) begin
            if (rem_inv != '0) begin
                o_msg.kind <= OUT_INVAL;
                o_msg.dst  <= NW'(low_index(64'(rem_inv)));
                o_msg.data <= '0;
                rem_inv    <= rem_inv & (rem_inv - NODES'(1));
            end else if (rem_fetch) begin
                o_msg.kind <= OUT_FETCH;
                o_msg.dst  <= f_dst;
                o_msg.node <= f_node;
                o_msg.data <= '0;
                rem_fetch  <= 1'b0;
            end else begin
                o_valid <= 1'b0;
            end
        end
    end

    assign out_valid = o_valid;
    assign out_kind  = o_msg.kind;
    assign out_dst   = o_msg.dst;
    assign out_blk   = o_msg.blk;
    assign out_node  = o_msg.node;
    assign out_data  = o_msg.data;

endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
    parameter int  NODES  = 4,
    parameter int  BLOCKS = 16,
    parameter int  DW     = 32,
    localparam int NW     = $clog2(NODES),
    localparam int BW     = $clog2(BLOCKS)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [1:0]        in_kind,
    input logic [NW-1:0]     in_src,
    input logic [BW-1:0]     in_blk,
    input logic              out_valid,
    input logic              out_ready,
    input logic [2:0]        out_kind,
    input logic [NW-1:0]     out_dst,
    input logic [BW-1:0]     out_blk,
    input logic [NW-1:0]     out_node,
    input logic [DW-1:0]     out_data,
    input logic [1:0]        look_state,
    input logic [NODES-1:0]  look_presence,
    input logic              look_modified,
    input logic [BLOCKS-1:0] busy_vec
);

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_dst)
            && $stable(out_blk) && $stable(out_node) && $stable(out_data));

    // R10
    no_take_while_send_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R1
    uncached_empty_chk: assert property (@(posedge clk) disable iff (rst)
        look_state == 2'd0 |-> look_presence == '0 && !look_modified);

    // R2
    shared_clean_chk: assert property (@(posedge clk) disable iff (rst)
        look_state == 2'd1 |-> !look_modified && look_presence != '0);

    // R6
    dirty_single_chk: assert property (@(posedge clk) disable iff (rst)
        look_state == 2'd2 |-> look_modified && $countones(look_presence) == 1);

    // R8
    busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (in_kind == 2'd0 || in_kind == 2'd1) && busy_vec[in_blk]
            |=> out_valid && out_kind == 3'd4 && out_dst == $past(in_src));

endmodule

bind dir_home_ctrl dir_home_chk #(.NODES(NODES), .BLOCKS(BLOCKS), .DW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_kind       (in_kind),
    .in_src        (in_src),
    .in_blk        (in_blk),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_kind      (out_kind),
    .out_dst       (out_dst),
    .out_blk       (out_blk),
    .out_node      (out_node),
    .out_data      (out_data),
    .look_state    (look_state),
    .look_presence (look_presence),
    .look_modified (look_modified),
    .busy_vec      (busy_vec)
);

// File: tb/tb_dir_home_ctrl.sv
module tb_dir_home_ctrl;

    localparam int NODES  = 4;
    localparam int BLOCKS = 16;
    localparam int DW     = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_kind = '0;
    logic [1:0]  in_src = '0;
    logic [3:0]  in_blk = '0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [2:0]  out_kind;
    logic [1:0]  out_dst;
    logic [3:0]  out_blk;
    logic [1:0]  out_node;
    logic [31:0] out_data;
    logic [3:0]  look_blk = '0;
    logic [1:0]  look_state;
    logic [3:0]  look_presence;
    logic        look_modified;

    always #2 clk = ~clk;

    dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DW(DW)) dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
        .in_src(in_src), .in_blk(in_blk), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_dst(out_dst), .out_blk(out_blk), .out_node(out_node), .out_data(out_data),
        .look_blk(look_blk), .look_state(look_state),
        .look_presence(look_presence), .look_modified(look_modified)
    );

    typedef struct {
        logic [2:0]  kind;
        logic [1:0]  dst;
        logic [1:0]  node;
        logic [3:0]  blk;
        logic [31:0] data;
        string       tag;
    } exp_t;

    typedef struct {
        int          kind;
        int          src;
        int          blk;
        logic [31:0] data;
    } cmp_t;

    exp_t exp_q[$];
    cmp_t comp_q[$];
    exp_t mon_e;
    int   total = 0;
    int   bad = 0;
    bit   gen_comp = 0;
    int   rdy_ctl = 1;

    // reference directory and transaction state
    logic [1:0]  r_st   [BLOCKS];
    logic [3:0]  r_pres [BLOCKS];
    logic        r_mod  [BLOCKS];
    logic [31:0] r_mem  [BLOCKS];
    bit          p_busy [BLOCKS];
    bit          p_wr   [BLOCKS];
    bit          p_odty [BLOCKS];
    int          p_req  [BLOCKS];
    int          p_own  [BLOCKS];
    logic [3:0]  p_wait [BLOCKS];
    int          p_cnt  [BLOCKS];

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    function automatic int low4(logic [3:0] v);
        int r = 0;
        for (int i = 3; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    task automatic push(int k, int dst, int node, int blk, logic [31:0] d, string tag);
        exp_t e;
        e.kind = 3'(k); e.dst = 2'(dst); e.node = 2'(node);
        e.blk = 4'(blk); e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic add_comp(int k, int src, int blk);
        cmp_t c;
        c.kind = k; c.src = src; c.blk = blk; c.data = $urandom;
        comp_q.push_back(c);
    endtask

    // reference model: predicts the messages and the entry update
    task automatic model(int k, int src, int b, logic [31:0] d);
        logic [3:0] sb, oth;
        bit oa;
        sb = 4'(1) << src;
        case (k)
            0: begin
                if (p_busy[b]) push(4, src, src, b, 0, "R8");
                else if (r_st[b] == 2) begin
                    int o = low4(r_pres[b]);
                    push(1, src, o, b, 0, "R3");
                    push(5, o, src, b, 0, "R3");
                    p_busy[b] = 1; p_wr[b] = 0; p_req[b] = src; p_own[b] = o;
                    if (gen_comp) add_comp(3, o, b);
                end else begin
                    push(0, src, src, b, r_mem[b], "R2");
                    r_pres[b] = r_pres[b] | sb; r_st[b] = 1; r_mod[b] = 0;
                end
            end
            1: begin
                oth = r_pres[b] & ~sb;
                if (p_busy[b]) push(4, src, src, b, 0, "R8");
                else if (oth == 0) begin
                    push(3, src, src, b, r_mem[b], "R7");
                    r_st[b] = 2; r_pres[b] = sb; r_mod[b] = 1;
                end else begin
                    p_busy[b] = 1; p_wr[b] = 1; p_req[b] = src;
                    p_own[b] = low4(r_pres[b]); p_odty[b] = (r_st[b] == 2);
                    p_wait[b] = oth; p_cnt[b] = $countones(oth);
                    for (int n = 0; n < NODES; n++) begin
                        if (oth[n]) begin
                            push(2, n, src, b, 0, "R5");
                            if (gen_comp) add_comp(2, n, b);
                        end
                    end
                end
            end
            2: begin
                if (p_busy[b] && p_wr[b] && p_wait[b][src]) begin
                    p_wait[b][src] = 1'b0;
                    p_cnt[b]--;
                    oa = p_odty[b] && (src == p_own[b]);
                    if (oa) r_mem[b] = d;
                    if (p_cnt[b] == 0) begin
                        push(3, p_req[b], p_req[b], b, r_mem[b], oa ? "R11" : "R6");
                        r_st[b] = 2; r_pres[b] = 4'(1) << p_req[b]; r_mod[b] = 1;
                        p_busy[b] = 0;
                    end
                end
            end
            default: begin
                if (p_busy[b] && !p_wr[b] && src == p_own[b]) begin
                    r_mem[b] = d;
                    r_pres[b] = (4'(1) << p_own[b]) | (4'(1) << p_req[b]);
                    r_mod[b] = 0; r_st[b] = 1; p_busy[b] = 0;
                end
            end
        endcase
    endtask

    task automatic look_check(int b, string tag);
        look_blk = 4'(b);
        #1;
        chk({look_state, look_presence, look_modified} == {r_st[b], r_pres[b], r_mod[b]},
            tag, "directory entry",
            64'({look_state, look_presence, look_modified}),
            64'({r_st[b], r_pres[b], r_mod[b]}));
    endtask

    task automatic drain();
        @(negedge clk); #1;
        while (exp_q.size() != 0 || out_valid) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic send(int k, int src, int b, logic [31:0] d, string tag, bit wait_out);
        model(k, src, b, d);
        @(negedge clk);
        in_valid = 1'b1; in_kind = 2'(k); in_src = 2'(src); in_blk = 4'(b); in_data = d;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
        if (wait_out) begin
            drain();
            look_check(b, tag);
        end
    endtask

    // output readiness
    initial begin
        forever begin
            @(posedge clk);
            #1;
            case (rdy_ctl)
                0:       out_ready = ($urandom % 4) != 0;
                1:       out_ready = 1'b1;
                default: out_ready = 1'b0;
            endcase
        end
    end

    // monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            chk(!in_ready, "R10", "in_ready while sending", 64'(in_ready), 64'(0));
            if (out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "unexpected message",
                        64'({out_kind, out_dst, out_node, out_blk, out_data}), 64'(0));
                end else begin
                    mon_e = exp_q.pop_front();
                    chk({out_kind, out_dst, out_node, out_blk, out_data} ==
                        {mon_e.kind, mon_e.dst, mon_e.node, mon_e.blk, mon_e.data},
                        mon_e.tag, "message",
                        64'({out_kind, out_dst, out_node, out_blk, out_data}),
                        64'({mon_e.kind, mon_e.dst, mon_e.node, mon_e.blk, mon_e.data}));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int b = 0; b < BLOCKS; b++) begin
            r_st[b] = 0; r_pres[b] = 0; r_mod[b] = 0; r_mem[b] = 32'hC0DE_0000 + b;
            p_busy[b] = 0; p_wr[b] = 0; p_odty[b] = 0; p_req[b] = 0; p_own[b] = 0;
            p_wait[b] = 0; p_cnt[b] = 0;
        end
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(in_ready && !out_valid, "R1", "handshake after reset",
            64'({in_ready, out_valid}), 64'(2'b10));
        for (int b = 0; b < BLOCKS; b++) look_check(b, "R1");

        // R2 clean reads
        send(0, 1, 0, 0, "R2", 1);
        send(0, 2, 0, 0, "R2", 1);
        // R5 write with two other sharers
        send(1, 3, 0, 0, "R5", 1);
        // R8 miss to the open block
        send(0, 0, 0, 0, "R8", 1);
        send(1, 1, 0, 0, "R8", 1);
        // R9 strays
        send(2, 0, 0, 32'h1111_1111, "R9", 1);
        send(3, 1, 0, 32'h2222_2222, "R9", 1);
        // R6 acks, grant on the last
        send(2, 2, 0, 0, "R6", 1);
        send(2, 2, 0, 0, "R9", 1);
        send(2, 1, 0, 0, "R6", 1);
        // R3 read of dirty block
        send(0, 0, 0, 0, "R3", 1);
        send(3, 2, 0, 32'h3333_3333, "R9", 1);
        // R4 owner return
        send(3, 3, 0, 32'h1234_5678, "R4", 1);
        send(0, 1, 0, 0, "R4", 1);
        // R7 immediate grant
        send(1, 2, 5, 0, "R7", 1);
        // R11 dirty owner ack carries data
        send(1, 0, 5, 0, "R11", 1);
        send(2, 2, 5, 32'hBEEF_0005, "R11", 1);
        send(0, 3, 5, 0, "R11", 1);

        // R10 stalled output
        send(0, 0, 7, 0, "R2", 1);
        send(0, 1, 7, 0, "R2", 1);
        send(0, 2, 7, 0, "R2", 1);
        rdy_ctl = 2;
        @(posedge clk);
        send(1, 3, 7, 0, "R10", 0);
        repeat (6) @(negedge clk);
        chk(out_valid && out_kind == 3'd2 && out_dst == 2'd0 && !in_ready, "R10",
            "held invalidate", 64'({out_valid, out_kind, out_dst, in_ready}),
            64'({1'b1, 3'd2, 2'd0, 1'b0}));
        rdy_ctl = 1;
        drain();
        look_check(7, "R5");
        send(2, 0, 7, 0, "R6", 1);
        send(2, 1, 7, 0, "R6", 1);
        send(2, 2, 7, 0, "R6", 1);

        // random sequences
        gen_comp = 1;
        rdy_ctl = 0;
        for (int i = 0; i < 600; i++) begin
            if (comp_q.size() > 0 && ($urandom % 2) == 1) begin
                int idx = int'($urandom % comp_q.size());
                cmp_t c = comp_q[idx];
                comp_q.delete(idx);
                send(c.kind, c.src, c.blk, c.data, "R6", 1);
            end else if (($urandom % 16) == 0) begin
                send(2 + int'($urandom % 2), int'($urandom % 4), int'($urandom % 4),
                     $urandom, "R9", 1);
            end else begin
                send(int'($urandom % 2), int'($urandom % 4), int'($urandom % 4), 0, "R2", 1);
            end
        end
        while (comp_q.size() > 0) begin
            cmp_t c = comp_q.pop_front();
            send(c.kind, c.src, c.blk, c.data, "R4", 1);
        end
        rdy_ctl = 1;
        drain();
        for (int b = 0; b < BLOCKS; b++) look_check(b, "R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule